// File: doc/BRIEF.md
# MII Management Auto-Poll Engine

This block is the station-management master for an external Ethernet PHY. It derives a management clock from the system clock, using a two-bit rate code to pick the division. It runs clause-22 read and write frames on a bidirectional data line, which it drives through an output value and an output enable. A host port asks for single reads or writes of any PHY register. When polling is enabled, the block keeps re-reading the PHY status register (register 1) by itself and raises a sticky interrupt when the value it reads differs from the one it stored last time.

Between frames, the idle level of the data line is tracked as a PHY-presence flag. A pull-down on the line reads as no PHY, and a pull-up reads as a PHY being present. During a frame the flag is frozen, so the frame's own bit pattern never disturbs it. Any change of the flag sets a sticky interrupt. When auto-select is on, the flag also chooses the external MII port.

Top module: `mdio_autopoll_master`

## Requirements
- R1: The management clock `mdc` toggles every `HALF_DIV*k` system clocks. k is 4 for rate code 00 and for the reserved code 11, 2 for code 01, and 1 for code 10. A half period ends as soon as its counter reaches the limit of the code that is currently applied.
- R2: Each frame is sent MSB first and changes `mdio_out` only on a falling edge of `mdc`. It consists of:
  - 32 ones;
  - start 01;
  - opcode 10 for a read or 01 for a write;
  - the 5-bit `phy_addr`;
  - the 5-bit register address;
  - for writes only, turnaround 10 and 16 data bits.
- R3: In a read, `mdio_oe` is 0 from the first turnaround bit to the end of the frame. The 16 data bits are sampled MSB first on rising edges of `mdc`. A host read returns them on `host_rdata`, together with a one-cycle `host_done` pulse.
- R4: With no frame in progress, `phy_present` takes the level of `mdio_in` one system clock later. During a frame it holds the value it had when the frame started.
- R5: Any change of `phy_present` sets `irq_pd_chg`. `irq_pd_chg` stays set until `irq_clr[0]` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R6: `mii_port_sel` is 1 exactly when `auto_sel` is 1 and `phy_present` is 1.
- R7: While `poll_en` is 1 and `int_phy_sel` is 0, frames keep reading register 1 of `phy_addr` with no host frame in between. Each result is stored on `poll_status`.
- R8: A polled value that differs from the stored one sets `irq_stat_chg`, but only if `stat_int_en` is 1. `irq_stat_chg` is cleared by `irq_clr[1]`. The first poll after reset only stores its value.
- R9: No poll frame starts while `int_phy_sel` is 1 or `poll_en` is 0. In that state `mdio_oe` stays 0 unless the host asks for a frame.
- R10: A pending host request is served before the next poll frame. A frame that is already in progress always completes all 64 bits.
- R11: During reset, `mdc`, `mdio_oe`, `host_done`, `phy_present`, both interrupts and `poll_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Management clock rate code |
| auto_sel | input | 1 | Enable automatic MII port selection |
| poll_en | input | 1 | Enable autonomous status polling |
| stat_int_en | input | 1 | Enable status-change interrupt |
| int_phy_sel | input | 1 | Internal PHY is selected; suppresses polling |
| phy_addr | input | 5 | Address of the external PHY |
| host_req | input | 1 | Host frame request, held until host_done |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 5 | Host target register |
| host_wdata | input | 16 | Host write data |
| irq_clr | input | 2 | Clear pulses: bit 0 presence, bit 1 status |
| mdio_in | input | 1 | Sampled level of the data line |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| host_done | output | 1 | One-cycle pulse when a host frame ends |
| host_rdata | output | 16 | Data from the last host read |
| phy_present | output | 1 | PHY-presence flag |
| mii_port_sel | output | 1 | External MII port selected |
| poll_status | output | 16 | Last polled status value |
| irq_pd_chg | output | 1 | Sticky presence-change interrupt |
| irq_stat_chg | output | 1 | Sticky status-change interrupt |

## Verification
Some internal faults show up on `mdc` within one half period, on the next compare: a wrong divider count or a wrong rate decode. A wrong bit counter or shift state shows up within one frame. It corrupts the field pattern that the bench's PHY model decodes, or it returns the wrong read data one frame after the error. A presence flag that is not frozen moves during the first zero of a frame, and `irq_pd_chg` moves with it. A stored poll value that is wrong, or a valid flag that is wrong, gives a false or missing `irq_stat_chg` at the end of the next poll frame.

// File: rtl/mdio_pkg.sv
// Shared constants and the command type for the management master.
// Assumes clause-22 frames of exactly 64 management clock periods.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int HDR_BITS   = 46;   // preamble .. register address
    localparam int DATA_FIRST = 48;   // first data bit index
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [4:0] STATUS_REG = 5'd1;

    typedef struct packed {
        logic        wr;
        logic [4:0]  reg_a;
        logic [15:0] wdata;
    } mgmt_cmd_t;
endpackage

// File: rtl/mdc_clkgen.sv
// Management clock divider. Produces mdc and single-cycle tick strobes that
// coincide with the system clock edge at which mdc changes.
// Assumes HALF_DIV >= 1; reserved rate code 11 behaves like 00.
module mdc_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       mdc,
    output logic       rise_tick,
    output logic       fall_tick
);
    localparam int MAX_HALF = 4 * HALF_DIV;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half;
    logic          wrap;

    // Decode the rate code into a half-period length.
    always_comb begin
        case (rate_sel)
            2'b01:   half = CW'(2 * HALF_DIV);
            2'b10:   half = CW'(HALF_DIV);
            default: half = CW'(MAX_HALF);
        endcase
    end

    assign wrap      = (cnt >= half - 1'b1);
    assign rise_tick = wrap & ~mdc;
    assign fall_tick = wrap & mdc;

    // Count system clocks and toggle mdc at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Serialises one 64-bit management frame per accepted command. Drives on
// falling-tick edges, samples read data on rising-tick edges, releases the
// line from the read turnaround on. Assumes ticks from mdc_clkgen.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_tick,
    input  logic       fall_tick,
    input  logic       start_valid,
    input  mgmt_cmd_t  cmd,
    input  logic [4:0] phy_addr,
    input  logic       mdio_in,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic [15:0] rd_data,
    output logic       mdio_out,
    output logic       mdio_oe,
    output logic [5:0] bit_idx,
    output logic       cur_wr
);
    logic [FRAME_BITS-1:0] word;
    logic [FRAME_BITS-1:0] sreg;
    logic [6:0]            idx_next;

    assign accept   = fall_tick & ~busy & start_valid;
    assign idx_next = {1'b0, bit_idx} + 7'd1;

    // Assemble the frame image for the offered command.
    always_comb begin
        word = {32'hFFFF_FFFF, 2'b01, (cmd.wr ? OP_WR : OP_RD), phy_addr,
                cmd.reg_a, 2'b10, (cmd.wr ? cmd.wdata : 16'h0000)};
    end

    // Frame sequencing: start, shift out, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            bit_idx  <= '0;
            cur_wr   <= 1'b0;
            sreg     <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                cur_wr   <= cmd.wr;
                bit_idx  <= '0;
                mdio_out <= word[FRAME_BITS-1];
                mdio_oe  <= 1'b1;
                sreg     <= {word[FRAME_BITS-2:0], 1'b0};
            end else if (fall_tick && busy) begin
                if (bit_idx == 6'(FRAME_BITS - 1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    mdio_out <= 1'b1;
                    mdio_oe  <= 1'b0;
                end else begin
                    bit_idx  <= idx_next[5:0];
                    mdio_out <= sreg[FRAME_BITS-1];
                    mdio_oe  <= cur_wr | (idx_next < 7'(HDR_BITS));
                    sreg     <= {sreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    // Capture read data on rising ticks during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rise_tick && busy && !cur_wr && bit_idx >= 6'(DATA_FIRST)) begin
            rd_data <= {rd_data[14:0], mdio_in};
        end
    end
endmodule

// File: rtl/mdio_poll_arb.sv
// Chooses the next frame (host first, then status poll), routes results back
// to the host or to the stored status, and flags status changes.
// Assumes host_req is held until host_done.
module mdio_poll_arb
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req,
    input  logic       host_wr,
    input  logic [4:0] host_reg,
    input  logic [15:0] host_wdata,
    input  logic       poll_en,
    input  logic       int_phy_sel,
    input  logic       stat_int_en,
    input  logic       accept,
    input  logic       done,
    input  logic [15:0] rd_data,
    output logic       start_valid,
    output mgmt_cmd_t  cmd,
    output logic       owner_host,
    output logic       host_done,
    output logic [15:0] host_rdata,
    output logic [15:0] poll_status,
    output logic       stat_changed
);
    logic poll_ok;
    logic stat_valid;

    assign poll_ok     = poll_en & ~int_phy_sel;
    assign start_valid = host_req | poll_ok;

    // Select the command offered to the frame engine.
    always_comb begin
        if (host_req) begin
            cmd = '{wr: host_wr, reg_a: host_reg, wdata: host_wdata};
        end else begin
            cmd = '{wr: 1'b0, reg_a: STATUS_REG, wdata: 16'h0000};
        end
    end

    assign stat_changed = done & ~owner_host & stat_valid &
                          (rd_data != poll_status) & stat_int_en;

    // Remember which requester owns the running frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_host <= 1'b0;
        end else if (accept) begin
            owner_host <= host_req;
        end
    end

    // Deliver results to the host or to the stored status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_done   <= 1'b0;
            host_rdata  <= '0;
            poll_status <= '0;
            stat_valid  <= 1'b0;
        end else begin
            host_done <= done & owner_host;
            if (done && owner_host) begin
                host_rdata <= rd_data;
            end
            if (done && !owner_host) begin
                poll_status <= rd_data;
                stat_valid  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_status_track.sv
// Presence flag from the idle data-line level, port selection, and the two
// sticky interrupt bits. Assumes busy covers the whole frame.
module mdio_status_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdio_in,
    input  logic       busy,
    input  logic       auto_sel,
    input  logic [1:0] irq_clr,
    input  logic       stat_changed,
    output logic       phy_present,
    output logic       mii_port_sel,
    output logic       irq_pd_chg,
    output logic       irq_stat_chg
);
    logic pd_move;

    assign pd_move      = ~busy & (mdio_in != phy_present);
    assign mii_port_sel = auto_sel & phy_present;

    // Follow the idle line level; hold it while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_present <= 1'b0;
        end else if (!busy) begin
            phy_present <= mdio_in;
        end
    end

    // Sticky interrupt bits: setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pd_chg   <= 1'b0;
            irq_stat_chg <= 1'b0;
        end else begin
            if (pd_move)         irq_pd_chg <= 1'b1;
            else if (irq_clr[0]) irq_pd_chg <= 1'b0;
            if (stat_changed)    irq_stat_chg <= 1'b1;
            else if (irq_clr[1]) irq_stat_chg <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_autopoll_master.sv
// Top level of the management master: clock divider, frame engine, request
// arbiter with status polling, and presence/interrupt tracking.
// Assumes mdio_in is already synchronous to clk.
module mdio_autopoll_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  rate_sel,
    input  logic        auto_sel,
    input  logic        poll_en,
    input  logic        stat_int_en,
    input  logic        int_phy_sel,
    input  logic [4:0]  phy_addr,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic [4:0]  host_reg,
    input  logic [15:0] host_wdata,
    input  logic [1:0]  irq_clr,
    input  logic        mdio_in,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        host_done,
    output logic [15:0] host_rdata,
    output logic        phy_present,
    output logic        mii_port_sel,
    output logic [15:0] poll_status,
    output logic        irq_pd_chg,
    output logic        irq_stat_chg
);
    logic        rise_tick, fall_tick;
    logic        start_valid, eng_accept, eng_busy, eng_done;
    logic [15:0] eng_rdata;
    logic [5:0]  bit_idx;
    logic        cur_wr, owner_host, stat_changed;
    mgmt_cmd_t   cmd;

    mdc_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .start_valid(start_valid), .cmd(cmd), .phy_addr(phy_addr),
        .mdio_in(mdio_in), .accept(eng_accept), .busy(eng_busy),
        .done(eng_done), .rd_data(eng_rdata), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .bit_idx(bit_idx), .cur_wr(cur_wr)
    );

    mdio_poll_arb u_arb (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_reg(host_reg), .host_wdata(host_wdata), .poll_en(poll_en),
        .int_phy_sel(int_phy_sel), .stat_int_en(stat_int_en),
        .accept(eng_accept), .done(eng_done), .rd_data(eng_rdata),
        .start_valid(start_valid), .cmd(cmd), .owner_host(owner_host),
        .host_done(host_done), .host_rdata(host_rdata),
        .poll_status(poll_status), .stat_changed(stat_changed)
    );

    mdio_status_track u_trk (
        .clk(clk), .rst_n(rst_n), .mdio_in(mdio_in), .busy(eng_busy),
        .auto_sel(auto_sel), .irq_clr(irq_clr), .stat_changed(stat_changed),
        .phy_present(phy_present), .mii_port_sel(mii_port_sel),
        .irq_pd_chg(irq_pd_chg), .irq_stat_chg(irq_stat_chg)
    );
endmodule

// File: rtl/mdio_autopoll_checker.sv
// Protocol and state properties of the management master, bound to the top.
module mdio_autopoll_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mdc,
    input logic       mdio_out,
    input logic       mdio_oe,
    input logic       phy_present,
    input logic       irq_pd_chg,
    input logic       irq_stat_chg,
    input logic       stat_int_en,
    input logic       busy,
    input logic       owner_host,
    input logic       host_req,
    input logic       poll_en,
    input logic       int_phy_sel,
    input logic [5:0] bit_idx,
    input logic       cur_wr
);
    // R2: drive value moves only together with a falling mdc
    p_drive_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_out) |-> $fell(mdc));

    // R3: line released during read turnaround and data
    p_release_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cur_wr && bit_idx >= 6'd46) |-> !mdio_oe);

    // R4: presence flag frozen inside a frame
    p_pd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(phy_present));

    // R5: every presence change leaves the interrupt set
    p_pd_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phy_present) |-> irq_pd_chg);

    // R8: status interrupt only rises when enabled
    p_stat_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat_chg) |-> $past(stat_int_en));

    // R9: a poll frame never starts with polling blocked
    p_no_poll_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (owner_host || ($past(poll_en) && !$past(int_phy_sel))));

    // R10: a waiting host request wins the next frame
    p_host_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(host_req)) |-> owner_host);
endmodule

bind mdio_autopoll_master mdio_autopoll_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .phy_present(phy_present), .irq_pd_chg(irq_pd_chg),
    .irq_stat_chg(irq_stat_chg), .stat_int_en(stat_int_en), .busy(eng_busy),
    .owner_host(owner_host), .host_req(host_req), .poll_en(poll_en),
    .int_phy_sel(int_phy_sel), .bit_idx(bit_idx), .cur_wr(cur_wr)
);

// File: tb/sim_mdio_autopoll_master.sv
`timescale 1ns/1ps
module sim_mdio_autopoll_master;
    localparam int H = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        rst_n;
    logic [1:0]  rate_sel;
    logic        auto_sel, poll_en, stat_int_en, int_phy_sel;
    logic [4:0]  phy_addr, host_reg;
    logic        host_req, host_wr;
    logic [15:0] host_wdata;
    logic [1:0]  irq_clr;
    logic        mdio_in, mdc, mdio_out, mdio_oe, host_done;
    logic [15:0] host_rdata, poll_status;
    logic        phy_present, mii_port_sel, irq_pd_chg, irq_stat_chg;

    logic idle_lvl, phy_drv_en, phy_drv;
    assign mdio_in = mdio_oe ? mdio_out : (phy_drv_en ? phy_drv : idle_lvl);

    mdio_autopoll_master #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .auto_sel(auto_sel),
        .poll_en(poll_en), .stat_int_en(stat_int_en), .int_phy_sel(int_phy_sel),
        .phy_addr(phy_addr), .host_req(host_req), .host_wr(host_wr),
        .host_reg(host_reg), .host_wdata(host_wdata), .irq_clr(irq_clr),
        .mdio_in(mdio_in), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .host_done(host_done), .host_rdata(host_rdata),
        .phy_present(phy_present), .mii_port_sel(mii_port_sel),
        .poll_status(poll_status), .irq_pd_chg(irq_pd_chg),
        .irq_stat_chg(irq_stat_chg)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------- behavioural clock reference (R1) ----------
    int  mh;
    logic mdc_m;
    always @(posedge clk) begin
        int lim;
        if (!rst_n) begin
            mh = 0; mdc_m = 1'b0;
        end else begin
            lim = (rate_sel == 2'b01) ? 2*H : ((rate_sel == 2'b10) ? H : 4*H);
            if (mh >= lim - 1) begin mh = 0; mdc_m = ~mdc_m; end
            else mh++;
        end
    end

    // ---------- per-clock comparison ----------
    logic pd_prev, oe_prev, live;
    int   oe_seen;
    initial live = 1'b0;
    always @(negedge clk) begin
        if (live) begin
            chk("R1 mdc", mdc, mdc_m);
            chk("R6 port select", mii_port_sel, auto_sel & phy_present);
            if (phy_present !== pd_prev) chk("R5 change sets irq", irq_pd_chg, 1'b1);
            if (mdio_oe && oe_prev) chk("R4 hold in frame", phy_present, pd_prev);
            if (mdio_oe) oe_seen++;
        end
        pd_prev = phy_present;
        oe_prev = mdio_oe;
    end

    // ---------- PHY model ----------
    int ones = 0, pst = 0, hb = 0, step = 0, frames = 0, oe_clash = 0;
    logic [11:0] hdr;
    logic [17:0] wbits;
    logic [15:0] rdv, phy_status, rd_val, wdata_seen;
    logic [1:0]  op_seen, ta_seen;
    logic [4:0]  phy_seen, reg_seen;
    int reg_log[$];

    always @(posedge mdc) begin
        case (pst)
            0: if (mdio_in) ones++;
               else begin if (ones >= 32) pst = 1; ones = 0; end
            1: begin pst = mdio_in ? 2 : 0; hb = 0; end
            2: begin
                hdr = {hdr[10:0], mdio_in}; hb++;
                if (hb == 12) begin
                    op_seen = hdr[11:10]; phy_seen = hdr[9:5]; reg_seen = hdr[4:0];
                    reg_log.push_back(int'(reg_seen));
                    frames++;
                    if (op_seen == 2'b10) begin
                        pst = 4; step = 0;
                        rdv = (reg_seen == 5'd1) ? phy_status : rd_val;
                    end else if (op_seen == 2'b01) begin
                        pst = 3; hb = 0;
                    end else begin
                        pst = 0; ones = 0;
                    end
                end
            end
            3: begin
                wbits = {wbits[16:0], mdio_in}; hb++;
                if (hb == 18) begin
                    ta_seen = wbits[17:16]; wdata_seen = wbits[15:0];
                    pst = 0; ones = 0;
                end
            end
            4: if (step >= 1 && mdio_oe) oe_clash++;
            default: pst = 0;
        endcase
    end

    always @(negedge mdc) begin
        if (pst == 4) begin
            if (step == 0) phy_drv_en = 1'b0;
            else if (step == 1) begin phy_drv_en = 1'b1; phy_drv = 1'b0; end
            else if (step <= 17) phy_drv = rdv[17-step];
            else begin phy_drv_en = 1'b0; pst = 0; ones = 0; end
            step++;
        end
    end

    // ---------- helpers ----------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_op(input logic wr, input logic [4:0] ra, input logic [15:0] wd,
                           output logic [15:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_reg = ra; host_wdata = wd;
        do @(negedge clk); while (!host_done);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic wait_poll(input logic [15:0] v);
        while (poll_status !== v) @(negedge clk);
        cyc(2);
    endtask

    task automatic wait_frames(input int n);
        int f0 = frames;
        while (frames < f0 + n) @(negedge clk);
        while (pst != 0) @(negedge clk);
        cyc(40);
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk); irq_clr = m;
        @(negedge clk); irq_clr = 2'b00;
    endtask

    // ---------- watchdog ----------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // ---------- stimulus ----------
    initial begin
        logic [15:0] r;
        int f;
        rst_n = 1'b0; rate_sel = 2'b00; auto_sel = 0; poll_en = 0; stat_int_en = 0;
        int_phy_sel = 0; phy_addr = 5'h13; host_req = 0; host_wr = 0; host_reg = 0;
        host_wdata = 0; irq_clr = 0; idle_lvl = 1'b1; phy_drv_en = 0; phy_drv = 0;
        phy_status = 16'h0; rd_val = 16'h0;
        cyc(5);
        // R11 reset state
        chk("R11 mdc", mdc, 0);           chk("R11 oe", mdio_oe, 0);
        chk("R11 pd", phy_present, 0);    chk("R11 irq pd", irq_pd_chg, 0);
        chk("R11 irq stat", irq_stat_chg, 0);
        chk("R11 poll_status", poll_status, 0); chk("R11 host_done", host_done, 0);
        rst_n = 1'b1;
        live = 1'b1;
        cyc(10);
        // R4 / R5 / R6 presence
        chk("R4 idle high", phy_present, 1);
        chk("R5 rise sets irq", irq_pd_chg, 1);
        pulse_clr(2'b01); cyc(1);
        chk("R5 cleared", irq_pd_chg, 0);
        auto_sel = 1'b1; cyc(1);
        chk("R6 selected", mii_port_sel, 1);
        idle_lvl = 1'b0; cyc(3);
        chk("R4 idle low", phy_present, 0);
        chk("R5 fall sets irq", irq_pd_chg, 1);
        chk("R6 deselected", mii_port_sel, 0);
        idle_lvl = 1'b1; cyc(3);
        pulse_clr(2'b01); cyc(1);

        // R2 host write
        host_op(1'b1, 5'd5, 16'hA5C3, r);
        cyc(20);
        chk("R2 write op", op_seen, 2'b01);
        chk("R2 phy addr", phy_seen, 5'h13);
        chk("R2 reg addr", reg_seen, 5'd5);
        chk("R2 write ta", ta_seen, 2'b10);
        chk("R2 write data", wdata_seen, 16'hA5C3);

        // R3 host read of zeros; R4 flag must not follow the frame
        rd_val = 16'h0000;
        host_op(1'b0, 5'd2, 16'h0, r);
        chk("R3 read zeros", r, 16'h0000);
        chk("R2 read op", op_seen, 2'b10);
        chk("R4 held through frame", phy_present, 1);
        chk("R4 no irq from frame", irq_pd_chg, 0);

        // R1 / R3 other rates
        rate_sel = 2'b01; rd_val = 16'h8E71;
        host_op(1'b0, 5'd7, 16'h0, r);
        chk("R3 read rate01", r, 16'h8E71);
        rate_sel = 2'b10; rd_val = 16'h1F0C;
        host_op(1'b0, 5'd9, 16'h0, r);
        chk("R3 read rate10", r, 16'h1F0C);
        rate_sel = 2'b11;
        host_op(1'b1, 5'd30, 16'h6D2B, r);
        cyc(20);
        chk("R2 write rate11", wdata_seen, 16'h6D2B);
        rate_sel = 2'b00;
        chk("R3 no drive clash", oe_clash, 0);

        // R7 / R8 polling
        phy_status = 16'h1234; stat_int_en = 1'b1; poll_en = 1'b1;
        wait_poll(16'h1234);
        chk("R7 polled value", poll_status, 16'h1234);
        chk("R7 polls reg 1", reg_log[$], 1);
        chk("R8 first poll only stores", irq_stat_chg, 0);
        phy_status = 16'h5678;
        wait_poll(16'h5678);
        chk("R8 change raises irq", irq_stat_chg, 1);
        pulse_clr(2'b10);
        wait_frames(2);
        chk("R8 unchanged status no irq", irq_stat_chg, 0);

        // R10 host request during a poll frame
        while (pst != 2) @(negedge clk);
        rd_val = 16'h4242;
        host_op(1'b0, 5'd3, 16'h0, r);
        chk("R10 host data after poll", r, 16'h4242);
        chk("R10 host frame next", reg_log[$], 3);
        chk("R10 poll frame completed first", reg_log[$-1], 1);

        // R8 disabled
        stat_int_en = 1'b0; phy_status = 16'h9ABC;
        wait_poll(16'h9ABC);
        chk("R8 disabled no irq", irq_stat_chg, 0);

        // R9 internal PHY blocks polling
        int_phy_sel = 1'b1;
        cyc(2000);
        f = frames; oe_seen = 0;
        cyc(3000);
        chk("R9 no frames internal", frames, f);
        chk("R9 line released", oe_seen, 0);
        int_phy_sel = 1'b0; poll_en = 1'b0;
        cyc(2000);
        f = frames; oe_seen = 0;
        cyc(2000);
        chk("R9 no frames disabled", frames, f);
        chk("R9 released disabled", oe_seen, 0);
        chk("R3 no drive clash end", oe_clash, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule